// File: doc/BRIEF.md
# Load Data Rotate and Extend

This block turns the raw word returned by memory into the value a load writes into its destination register, on a 32-bit processor that comes in two core variants. From the low address bits and the access size, it picks the addressed byte or halfword lane. It then applies the rotation and the sign or zero extension that the load type and the core variant call for. Misaligned word loads are rotated on both variants. A halfword at an odd address is rotated only on the legacy variant, and a signed one is then extended from its low byte.

The formatting is combinational and the result is captured in one output register. A `in_valid` pulse presents a load, and `out_valid` with the formatted data follows one clock later. `out_data` holds its value until the next valid load. The variant is chosen per load through an input, so a shared load unit can serve either core. The block has no state machine: its only state is the output register and the strobe, which a synchronous reset clears.

Top module: `ldfmt_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` are cleared to zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. `out_data` changes only after an edge where `in_valid` was high, and otherwise holds.
- R3: Size code 00 (byte) with `sign_ext` = 0 gives the byte at bit position 8*`addr_lo` in bits [7:0] of the result, and zeros in bits [31:8].
- R4: Size code 00 (byte) with `sign_ext` = 1 gives the same byte in bits [7:0], with bits [31:8] copied from bit 7 of that byte.
- R5: Size code 10 (word) gives `raw_word` rotated right by 8*`addr_lo` bits. `sign_ext` has no effect on this result.
- R6: Size code 01 (halfword) with `legacy_core` = 0 and `sign_ext` = 0 gives the halfword at bit position 16*`addr_lo[1]` in bits [15:0], and zeros above, for both values of `addr_lo[0]`.
- R7: Size code 01 with `legacy_core` = 0 and `sign_ext` = 1 extends that halfword from its bit 15, for both values of `addr_lo[0]`.
- R8: Size code 01 with `legacy_core` = 1 and `addr_lo[0]` = 0 gives the same result as R6 and R7: no rotation, with extension from bit 15.
- R9: Size code 01 with `legacy_core` = 1, `addr_lo[0]` = 1 and `sign_ext` = 0 gives the zero-filled halfword rotated right by 8. The result is {h[7:0], 16'h0000, h[15:8]}, where h is the selected halfword.
- R10: Size code 01 with `legacy_core` = 1, `addr_lo[0]` = 1 and `sign_ext` = 1 gives h[15:8] in bits [7:0], with bits [31:8] copied from h[15].
- R11: Size code 11 is formatted exactly like size code 10 (word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A load result is presented this cycle |
| raw_word | input | 32 | Aligned word read from memory |
| addr_lo | input | 2 | Low two bits of the load address |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| sign_ext | input | 1 | 1 for a signed byte or halfword load |
| legacy_core | input | 1 | 1 selects legacy-core halfword handling |
| out_valid | output | 1 | Formatted result valid, one cycle after in_valid |
| out_data | output | 32 | Formatted destination-register value |

## Verification
Every combination of size code, address offset, sign flag and core variant is applied with several raw words. Some of these words have distinct bytes, so a lane or rotation error shows up. Others have the top bit of each byte or halfword set or cleared on its own, so extension from bit 7 can be told apart from extension from bit 15. Running odd-address halfwords through both variants and both sign settings separates the rotate-then-byte-extend path from the plain halfword path. Running signed and unsigned word loads separates a word load from a load whose sign flag leaks into it. Idle cycles with a changing raw word check that the output register holds, and a mid-run reset checks that it clears.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/ldfmt_lane_pick.sv
// Selects one UNIT_W-wide lane of a word by index.
module ldfmt_lane_pick #(
    parameter int DATA_W = 32,
    parameter int UNIT_W = 8,
    localparam int N     = DATA_W / UNIT_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [UNIT_W-1:0] unit
);
    logic [UNIT_W-1:0] lanes [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lanes[g] = word[g*UNIT_W +: UNIT_W];
    end

    assign unit = lanes[idx];
endmodule

// File: rtl/ldfmt_rotr.sv
// Right rotation by amt * STEP_W bits, built as log stages.
module ldfmt_rotr #(
    parameter int DATA_W  = 32,
    parameter int STEP_W  = 8,
    parameter int SHIFT_W = 2
) (
    input  logic [DATA_W-1:0]  src,
    input  logic [SHIFT_W-1:0] amt,
    output logic [DATA_W-1:0]  dst
);
    logic [DATA_W-1:0] stage [SHIFT_W+1];

    assign stage[0] = src;

    for (genvar s = 0; s < SHIFT_W; s++) begin : g_stage
        localparam int K = (STEP_W << s) % DATA_W;
        if (K == 0) begin : g_nop
            assign stage[s+1] = stage[s];
        end else begin : g_rot
            assign stage[s+1] = amt[s] ? {stage[s][K-1:0], stage[s][DATA_W-1:K]}
                                       : stage[s];
        end
    end

    assign dst = stage[SHIFT_W];
endmodule

// File: rtl/ldfmt_extend.sv
// Widens SRC_W bits to DATA_W with sign or zero fill.
module ldfmt_extend #(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 8
) (
    input  logic [SRC_W-1:0]  src,
    input  logic              sign_en,
    output logic [DATA_W-1:0] dst
);
    assign dst = {{(DATA_W-SRC_W){sign_en & src[SRC_W-1]}}, src};
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
    import ldfmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  logic [1:0]        acc_size,
    input  logic              sign_ext,
    input  logic              legacy_core,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int ADDR_W  = $clog2(DATA_W / BYTE_W);
    localparam int HIDX_W  = (ADDR_W > 1) ? ADDR_W - 1 : 1;

    logic [BYTE_W-1:0] byte_lane;
    logic [HALF_W-1:0] half_lane;
    logic [DATA_W-1:0] word_rot;
    logic [DATA_W-1:0] half_zx;
    logic [DATA_W-1:0] half_rot;
    logic              half_odd_rot;
    logic [BYTE_W-1:0] byte_src;
    logic [DATA_W-1:0] byte_ext;
    logic [DATA_W-1:0] half_ext;
    logic [DATA_W-1:0] fmt;
    logic [HIDX_W-1:0] half_idx;

    assign half_idx     = HIDX_W'(addr_lo >> 1);
    assign half_odd_rot = legacy_core & addr_lo[0];

    ldfmt_lane_pick #(.DATA_W(DATA_W), .UNIT_W(BYTE_W)) u_byte_pick (
        .word (raw_word),
        .idx  (addr_lo),
        .unit (byte_lane)
    );

    ldfmt_lane_pick #(.DATA_W(DATA_W), .UNIT_W(HALF_W)) u_half_pick (
        .word (raw_word),
        .idx  (half_idx),
        .unit (half_lane)
    );

    ldfmt_rotr #(.DATA_W(DATA_W), .STEP_W(BYTE_W), .SHIFT_W(ADDR_W)) u_word_rot (
        .src (raw_word),
        .amt (addr_lo),
        .dst (word_rot)
    );

    assign half_zx = {{(DATA_W-HALF_W){1'b0}}, half_lane};

    ldfmt_rotr #(.DATA_W(DATA_W), .STEP_W(BYTE_W), .SHIFT_W(1)) u_half_rot (
        .src (half_zx),
        .amt (half_odd_rot),
        .dst (half_rot)
    );

    // A signed odd legacy halfword is extended like a byte after rotation.
    assign byte_src = (acc_size_e'(acc_size) == SZ_HALF) ? half_rot[BYTE_W-1:0] : byte_lane;

    ldfmt_extend #(.DATA_W(DATA_W), .SRC_W(BYTE_W)) u_byte_ext (
        .src     (byte_src),
        .sign_en (sign_ext),
        .dst     (byte_ext)
    );

    ldfmt_extend #(.DATA_W(DATA_W), .SRC_W(HALF_W)) u_half_ext (
        .src     (half_lane),
        .sign_en (sign_ext),
        .dst     (half_ext)
    );

    always_comb begin
        unique case (acc_size_e'(acc_size))
            SZ_BYTE: fmt = byte_ext;
            SZ_HALF: begin
                if (half_odd_rot)
                    fmt = sign_ext ? byte_ext : half_rot;
                else
                    fmt = half_ext;
            end
            SZ_WORD,
            SZ_WIDE: fmt = word_rot;
            default: fmt = word_rot;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= fmt;
        end
    end
endmodule

// File: rtl/ldfmt_checker.sv
module ldfmt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] raw_word,
    input logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input logic [1:0]        acc_size,
    input logic              sign_ext,
    input logic              legacy_core,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    logic [7:0] lane_byte;
    assign lane_byte = 8'(raw_word >> {addr_lo, 3'b000});

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_strobe_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=> $stable(out_data));

    assert_byte_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'b00 && !sign_ext)
            |=> (out_data[DATA_W-1:8] == '0 && out_data[7:0] == $past(lane_byte)));

    assert_byte_sign_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'b00 && sign_ext)
            |=> (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}
                 && out_data[7:0] == $past(lane_byte)));

    assert_word_low_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size[1])
            |=> (out_data[7:0] == $past(lane_byte)));

    assert_new_half_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'b01 && !legacy_core && !sign_ext)
            |=> (out_data[DATA_W-1:16] == '0));

    assert_new_half_sign_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'b01 && !legacy_core && sign_ext)
            |=> (out_data[DATA_W-1:16] == {(DATA_W-16){out_data[15]}}));

    assert_legacy_odd_signed_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_size == 2'b01 && legacy_core && addr_lo[0] && sign_ext)
            |=> (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}
                 && out_data[7:0] == $past(lane_byte)));
endmodule

bind ldfmt_top ldfmt_checker #(.DATA_W(DATA_W)) u_ldfmt_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .raw_word    (raw_word),
    .addr_lo     (addr_lo),
    .acc_size    (acc_size),
    .sign_ext    (sign_ext),
    .legacy_core (legacy_core),
    .out_valid   (out_valid),
    .out_data    (out_data)
);

// File: tb/tb_ldfmt_top.sv
`timescale 1ns/1ps
module tb_ldfmt_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] raw_word;
    logic [1:0]  addr_lo;
    logic [1:0]  acc_size;
    logic        sign_ext;
    logic        legacy_core;
    logic        out_valid;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    ldfmt_top dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .raw_word    (raw_word),
        .addr_lo     (addr_lo),
        .acc_size    (acc_size),
        .sign_ext    (sign_ext),
        .legacy_core (legacy_core),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    function automatic logic [31:0] sx8(input logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    function automatic logic [31:0] sx16(input logic [15:0] h);
        return {{16{h[15]}}, h};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] raw, input logic [1:0] a,
                                          input logic [1:0] sz, input logic sg, input logic leg);
        logic [7:0]  b;
        logic [15:0] h;
        logic [63:0] dbl;
        b   = 8'((raw >> (8 * a)) & 32'hFF);
        h   = 16'((raw >> (16 * a[1])) & 32'hFFFF);
        dbl = {raw, raw} >> (8 * a);
        case (sz)
            2'b00: return sg ? sx8(b) : {24'h0, b};
            2'b01: begin
                if (leg && a[0])
                    return sg ? sx8(h[15:8]) : ((32'(h) >> 8) | (32'(h) << 24));
                return sg ? sx16(h) : {16'h0, h};
            end
            default: return dbl[31:0];
        endcase
    endfunction

    function automatic string tag(input logic [1:0] a, input logic [1:0] sz,
                                  input logic sg, input logic leg);
        case (sz)
            2'b00: return sg ? "R4" : "R3";
            2'b01: begin
                if (!leg) return sg ? "R7" : "R6";
                if (!a[0]) return "R8";
                return sg ? "R10" : "R9";
            end
            2'b10: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; result is sampled at the next falling edge.
    task automatic do_load(input logic [31:0] raw, input logic [1:0] a, input logic [1:0] sz,
                           input logic sg, input logic leg);
        in_valid    = 1'b1;
        raw_word    = raw;
        addr_lo     = a;
        acc_size    = sz;
        sign_ext    = sg;
        legacy_core = leg;
        @(negedge clk);
        check("R2", {31'h0, out_valid}, 32'h1);
        check(tag(a, sz, sg, leg), out_data, model(raw, a, sz, sg, leg));
    endtask

    initial begin
        logic [31:0] pats [8];
        pats[0] = 32'h8877_6655;
        pats[1] = 32'h7F80_01FF;
        pats[2] = 32'h807F_FF01;
        pats[3] = 32'h0080_8000;
        pats[4] = 32'hFFFF_FFFF;
        pats[5] = 32'h1234_ABCD;
        pats[6] = 32'hA5C3_3C5A;
        pats[7] = 32'h0000_0000;

        rst = 1'b1; in_valid = 1'b0; raw_word = '0; addr_lo = '0;
        acc_size = '0; sign_ext = 1'b0; legacy_core = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", {31'h0, out_valid}, 32'h0);
        check("R1", out_data, 32'h0);
        rst = 1'b0;

        for (int p = 0; p < 8; p++)
            for (int sz = 0; sz < 4; sz++)
                for (int a = 0; a < 4; a++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int leg = 0; leg < 2; leg++)
                            do_load(pats[p], 2'(a), 2'(sz), 1'(sg), 1'(leg));

        // Idle: strobe drops, data holds while inputs move.
        do_load(32'hDEAD_BEEF, 2'd1, 2'b10, 1'b0, 1'b1);
        in_valid = 1'b0;
        raw_word = 32'h0BAD_F00D;
        acc_size = 2'b00;
        @(negedge clk);
        check("R2", {31'h0, out_valid}, 32'h0);
        check("R2", out_data, 32'hEFDE_ADBE);
        raw_word = 32'h1111_2222;
        @(negedge clk);
        check("R2", out_data, 32'hEFDE_ADBE);

        // Reset during activity clears the register.
        do_load(32'hCAFE_1234, 2'd0, 2'b10, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", {31'h0, out_valid}, 32'h0);
        check("R1", out_data, 32'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule